// File: doc/BRIEF.md
# Frequency-then-Phase Acquisition Sequencer

This block decides which of two loops drives the oscillator control in a clock and data recovery circuit that has a reference clock. After reset it enables only the frequency loop, which pulls the oscillator toward N times the reference. The oscillator reaches the block through a divide-by-N path as single-cycle `div_tick` pulses. The reference arrives as `ref_tick` pulses. The block measures frequency digitally: it counts divider pulses over a fixed window of reference pulses.

When enough consecutive windows show a frequency error inside the capture range of the phase loop, the block turns the frequency loop off. It then leaves one idle cycle and turns the phase loop on. When the phase loop reports loss of lock, the block returns to the frequency loop through the same kind of idle cycle. The two enables are never high together, so the two charge pumps never disturb the control node at once. The acceptance band is ±1 count in a 1024-count window. That band is far wider than a reference offset of a few ppm, so such an offset does not prevent the handover.

The states are `FREQ_ACQ`, `SWITCH_UP`, `PHASE_TRACK` and `SWITCH_DOWN`. The transitions are:
- **window-confirm**: `FREQ_ACQ` to `SWITCH_UP`.
- **gap-up**: `SWITCH_UP` to `PHASE_TRACK`.
- **lock-loss**: `PHASE_TRACK` to `SWITCH_DOWN`.
- **gap-down**: `SWITCH_DOWN` to `FREQ_ACQ`.

Top module: `acq_sequencer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `fll_en`=1, `pll_en`=0 and `locked`=0 (state `FREQ_ACQ`).
- R2: A window is 1024 `ref_tick` pulses seen in `FREQ_ACQ`. It closes on the clock edge of its 1024th pulse. The `div_tick` pulses in the window are counted, including one on that closing edge. The window is accepted when the count is 1023, 1024 or 1025, and rejected otherwise.
- R3: Window-confirm fires on the edge that closes the 4th consecutive accepted window. A rejected window resets the run of accepted windows to zero.
- R4: Window-confirm leads to exactly one cycle in `SWITCH_UP`, with both enables low. That cycle is followed by `PHASE_TRACK`, where `pll_en`=1 and `fll_en`=0.
- R5: In `PHASE_TRACK`, if `data_lock_lost` is high at a clock edge, the block spends one cycle in `SWITCH_DOWN` with both enables low. It then returns to `FREQ_ACQ`.
- R6: `fll_en` and `pll_en` are never high in the same cycle.
- R7: `locked` is high exactly when the state is `PHASE_TRACK` and `data_lock_lost` is low. It follows `data_lock_lost` in the same cycle.
- R8: Outside `FREQ_ACQ`, ticks are ignored and the window and run counters are held at zero. Each new acquisition therefore starts a fresh window with an empty run.
- R9: `data_lock_lost` has no effect in `FREQ_ACQ`.
- R10: The divider count saturates instead of wrapping. A window with up to 2048 divider pulses is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| div_tick | input | 1 | One-cycle pulse per divided-oscillator period |
| data_lock_lost | input | 1 | Phase loop reports loss of lock |
| fll_en | output | 1 | Enable for the frequency loop |
| pll_en | output | 1 | Enable for the phase loop |
| locked | output | 1 | Phase loop active and in lock |

## Verification
The hardest situation to reach is a run of accepted windows that is broken at the tolerance boundary. For example, three windows with counts of 1025, 1023 and 1024 followed by one with 1026 must not cause a handover. A second case is relocking after a fallback, where stale window counts would shift every later window. The stimulus builds each window from 2048 cycles with a reference pulse on every other cycle, and places the exact number of divider pulses at the start of the window. Each count is therefore known exactly. Ticks also keep running in the phase state before the fallback, so that any counting there would break the next acquisition.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        FREQ_ACQ    = 2'd0,
        SWITCH_UP   = 2'd1,
        PHASE_TRACK = 2'd2,
        SWITCH_DOWN = 2'd3
    } acq_state_t;
endpackage

// File: rtl/acq_freq_window.sv
module acq_freq_window #(
    parameter int WIN_REFS = 1024,
    parameter int TOL      = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_tick,
    input  logic div_tick,
    output logic win_done,
    output logic win_ok
);
    localparam int RW     = $clog2(WIN_REFS);
    localparam int DW     = $clog2(WIN_REFS + TOL + 2) + 1;
    localparam int LO     = WIN_REFS - TOL;
    localparam int HI     = WIN_REFS + TOL;
    localparam logic [DW-1:0] DMAX = '1;

    logic [RW-1:0] ref_cnt;
    logic [DW-1:0] div_cnt;
    logic [DW-1:0] div_total;

    // count including a divider pulse on the closing edge, saturating
    always_comb begin
        if (div_tick && (div_cnt != DMAX)) div_total = div_cnt + 1'b1;
        else                               div_total = div_cnt;
    end

    assign win_done = active && ref_tick && (ref_cnt == RW'(WIN_REFS - 1));
    assign win_ok   = (div_total >= DW'(LO)) && (div_total <= DW'(HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            div_cnt <= '0;
        end else if (!active || win_done) begin
            ref_cnt <= '0;
            div_cnt <= '0;
        end else begin
            if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
            div_cnt <= div_total;
        end
    end
endmodule

// File: rtl/acq_confirm.sv
module acq_confirm #(
    parameter int CONFIRM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic win_done,
    input  logic win_ok,
    output logic confirmed
);
    localparam int GW = $clog2(CONFIRM + 1);

    logic [GW-1:0] good_cnt;

    assign confirmed = win_done && win_ok && (good_cnt == GW'(CONFIRM - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
        end else if (!active || confirmed) begin
            good_cnt <= '0;
        end else if (win_done) begin
            if (win_ok) good_cnt <= good_cnt + 1'b1;
            else        good_cnt <= '0;
        end
    end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int WIN_REFS = 1024,
    parameter int TOL      = 1,
    parameter int CONFIRM  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic div_tick,
    input  logic data_lock_lost,
    output logic fll_en,
    output logic pll_en,
    output logic locked
);
    acq_state_t state, state_nx;
    logic active, win_done, win_ok, confirmed;

    assign active = (state == FREQ_ACQ);

    acq_freq_window #(.WIN_REFS(WIN_REFS), .TOL(TOL)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ref_tick (ref_tick),
        .div_tick (div_tick),
        .win_done (win_done),
        .win_ok   (win_ok)
    );

    acq_confirm #(.CONFIRM(CONFIRM)) u_confirm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .win_done  (win_done),
        .win_ok    (win_ok),
        .confirmed (confirmed)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            FREQ_ACQ:    if (confirmed) state_nx = SWITCH_UP;
            SWITCH_UP:   state_nx = PHASE_TRACK;
            PHASE_TRACK: if (data_lock_lost) state_nx = SWITCH_DOWN;
            SWITCH_DOWN: state_nx = FREQ_ACQ;
            default:     state_nx = FREQ_ACQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FREQ_ACQ;
        else        state <= state_nx;
    end

    always_comb begin
        fll_en = 1'b0;
        pll_en = 1'b0;
        locked = 1'b0;
        unique case (state)
            FREQ_ACQ:    fll_en = 1'b1;
            PHASE_TRACK: begin
                pll_en = 1'b1;
                locked = !data_lock_lost;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic data_lock_lost,
    input logic fll_en,
    input logic pll_en,
    input logic locked
);
    // R6
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fll_en && pll_en));

    // R4
    gap_before_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(!fll_en && !pll_en));

    // R4
    no_direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fll_en |=> !pll_en);

    // R5
    loss_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && data_lock_lost) |=> (!pll_en && !fll_en));

    // R5
    gap_returns_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |=> fll_en);

    // R7
    locked_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (pll_en && !data_lock_lost));

    // R7
    locked_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && !data_lock_lost) |-> locked);
endmodule

bind acq_sequencer acq_sequencer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_lock_lost (data_lock_lost),
    .fll_en         (fll_en),
    .pll_en         (pll_en),
    .locked         (locked)
);

// File: tb/tb_acq_sequencer.sv
`timescale 1ns/1ps
module tb_acq_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic div_tick = 1'b0;
    logic data_lock_lost = 1'b0;
    logic fll_en, pll_en, locked;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural model: 0 freq, 1 gap up, 2 phase, 3 gap down
    int m_state = 0;
    int m_refs = 0;
    int m_divs = 0;
    int m_good = 0;

    always #2 clk = ~clk;

    acq_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_tick(div_tick),
        .data_lock_lost(data_lock_lost), .fll_en(fll_en), .pll_en(pll_en),
        .locked(locked)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_refs = 0; m_divs = 0; m_good = 0;
        end else begin
            case (m_state)
                0: begin
                    if (ref_tick) m_refs = m_refs + 1;
                    if (div_tick) m_divs = m_divs + 1;
                    if (ref_tick && m_refs == 1024) begin
                        if (m_divs >= 1023 && m_divs <= 1025) m_good = m_good + 1;
                        else m_good = 0;
                        m_refs = 0; m_divs = 0;
                        if (m_good == 4) begin
                            m_good = 0; m_state = 1;
                        end
                    end
                end
                1: m_state = 2;
                2: if (data_lock_lost) m_state = 3;
                default: m_state = 0;
            endcase
            if (m_state != 0) begin
                m_refs = 0; m_divs = 0; m_good = 0;
            end
        end
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            check(fll_en == (m_state == 0), "R1 R2 R3 R5 R8 R10 fll_en", fll_en, m_state == 0);
            check(pll_en == (m_state == 2), "R4 R6 pll_en", pll_en, m_state == 2);
            check(locked == (m_state == 2 && !data_lock_lost), "R7 R9 locked", locked,
                  m_state == 2 && !data_lock_lost);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(); ref_tick = 1'b0; div_tick = 1'b0;
        end
    endtask

    // 2048 cycles, reference pulse on odd cycles, ndiv divider pulses first
    task automatic window(input int ndiv);
        for (int i = 0; i < 2048; i++) begin
            step();
            ref_tick = (i % 2) == 1;
            div_tick = i < ndiv;
        end
        step(); ref_tick = 1'b0; div_tick = 1'b0;
    endtask

    initial begin
        #1;
        check(fll_en && !pll_en && !locked, "R1 reset", {fll_en, pll_en, locked}, 3'b100);
        idle(4);
        rst_n = 1'b1;
        #0.5;
        check(fll_en && !pll_en && !locked, "R1 after reset", {fll_en, pll_en, locked}, 3'b100);
        idle(3);

        window(1000);
        window(2048);
        check(fll_en == 1'b1, "R10 saturated window rejected", fll_en, 1);

        window(1025); window(1023); window(1024); window(1026);
        check(fll_en == 1'b1, "R2 R3 count 1026 breaks run", fll_en, 1);

        step(); data_lock_lost = 1'b1;
        step(); data_lock_lost = 1'b0;
        check(fll_en && !pll_en, "R9 loss ignored in freq", fll_en, 1);

        window(1024); window(1024); window(1024); window(1022);
        check(fll_en == 1'b1, "R2 R3 count 1022 breaks run", fll_en, 1);

        window(1023); window(1024); window(1025);
        for (int i = 0; i < 2048; i++) begin
            step();
            ref_tick = (i % 2) == 1;
            div_tick = i < 1024;
        end
        step(); ref_tick = 1'b0; div_tick = 1'b0;
        check(!fll_en && !pll_en, "R4 gap after confirm", {fll_en, pll_en}, 0);
        step();
        check(pll_en && !fll_en && locked, "R4 R7 phase track", {fll_en, pll_en, locked}, 3'b011);

        window(1024);
        window(1000);
        check(pll_en && locked, "R8 ticks ignored in phase", pll_en, 1);

        step(); data_lock_lost = 1'b1;
        #0.5;
        check(locked == 1'b0, "R7 locked drops same cycle", locked, 0);
        step(); data_lock_lost = 1'b0;
        check(!fll_en && !pll_en, "R5 gap after loss", {fll_en, pll_en}, 0);
        step();
        check(fll_en && !pll_en, "R5 back to freq", {fll_en, pll_en}, 2'b10);

        window(1024); window(1025); window(1023); window(1024);
        step();
        check(pll_en && locked, "R8 fresh acquisition relocks", pll_en, 1);
        idle(5);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule